// File: doc/BRIEF.md
# Protection Context Switch Register

This block is a 32-bit control register for one bus master. It holds the protection context the master is running in and a single saved context. Software reads the register, and writes to it are filtered by the writer's own context and by a per-context permission mask. The processor also updates the register itself whenever it enters an exception handler.

A table of four handler vector addresses marks the designated handlers. Handler slot i switches to context i. Entering one of them pushes the running context into the saved field and loads the target context. The switch is refused with a one-cycle bus error when the running context is marked valid in a 16-bit vector. Entering any other handler restores the saved context into the active field. The handler-entry event is a one-cycle strobe that arrives together with the fetched vector address.

Top module: `ctx_switch_reg`

## Requirements
- R1: After reset, `rdData` reads 0 and `busErr` is 0. The active context always reads at bits [3:0] and the saved context at bits [19:16]. Every other bit always reads 0.
- R2: A software write (`regWrEn` high) from a writer whose context `wrCtx` is 0 loads `regWrData[3:0]` into the active field and `regWrData[19:16]` into the saved field, whatever `permMask` holds.
- R3: A software write from a nonzero `wrCtx` loads `regWrData[3:0]` into the active field only when `permMask[regWrData[3:0]]` is 1. Otherwise the active field keeps its value.
- R4: A software write from a nonzero `wrCtx` never changes the saved field.
- R5: A handler entry whose address matches table slot i targets context i. When that target equals the active context, both fields stay unchanged and no bus error is raised.
- R6: A designated entry whose target differs from the active context, made while `ctxValid[active]` is 1, leaves both fields unchanged. `busErr` is then high for exactly the one cycle after the entry.
- R7: A designated entry whose target differs from the active context, made while `ctxValid[active]` is 0, copies the active context into the saved field and loads the target into the active field.
- R8: A handler entry whose address matches no table slot loads the saved field into the active field and leaves the saved field unchanged.
- R9: When a handler entry and a software write occur in the same cycle, only the handler entry takes effect.
- R10: When several table slots hold the matching address, the lowest-numbered slot selects the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Software write strobe |
| regWrData | input | 32 | Software write data |
| wrCtx | input | 4 | Protection context of the writing master |
| permMask | input | 16 | Per-target-context write permission |
| rdData | output | 32 | Register read value |
| hdlEntry | input | 1 | One-cycle handler-entry strobe |
| hdlAddr | input | 32 | Fetched handler vector address |
| hdlAddrTab | input | 4 x 32 | Designated handler addresses; slot i targets context i |
| ctxValid | input | 16 | Per-context flag that refuses a switch away from that context |
| busErr | output | 1 | Bus-error pulse for a refused handler fetch |

## Verification
The assertions assume that `hdlAddrTab`, `ctxValid` and `permMask` are steady around the clock edge of each event, and that an entry event lasts a single cycle. The stimulus changes every input only at the falling edge, applies one event per step, and puts an idle step after every refused entry, so each bus-error pulse can be seen to end. The table normally holds four distinct addresses. Only the slot-priority test loads a duplicate.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {ACT_KEEP, ACT_TGT, ACT_SAV, ACT_WR} actSel_e;

  typedef struct packed {
    actSel_e actSel;
    logic    savFromAct;
    logic    savFromWr;
    logic    raiseErr;
  } ctxStrb_t;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int CTX_W   = 4,
  parameter int NUM_HDL = 4,
  parameter int ADDR_W  = 32
) (
  input  logic                            hdlEntry,
  input  logic [ADDR_W-1:0]               hdlAddr,
  input  logic [NUM_HDL-1:0][ADDR_W-1:0]  hdlAddrTab,
  input  logic [(1<<CTX_W)-1:0]           ctxValid,
  input  logic                            regWrEn,
  input  logic [CTX_W-1:0]                wrCtx,
  input  logic [CTX_W-1:0]                wrAct,
  input  logic [(1<<CTX_W)-1:0]           permMask,
  input  logic [CTX_W-1:0]                curAct,
  output ctxStrb_t                        strb,
  output logic [CTX_W-1:0]                tgtCtx
);
  localparam int IDX_W = (NUM_HDL > 1) ? $clog2(NUM_HDL) : 1;

  logic             hit;
  logic [IDX_W-1:0] hitIdx;

  // Scan from the top so the lowest matching slot is kept last (R10)
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    for (int i = NUM_HDL - 1; i >= 0; i--) begin
      if (hdlAddrTab[i] == hdlAddr) begin
        hit    = 1'b1;
        hitIdx = IDX_W'(i);
      end
    end
  end

  assign tgtCtx = CTX_W'(hitIdx);

  always_comb begin
    strb = '{actSel: ACT_KEEP, savFromAct: 1'b0, savFromWr: 1'b0, raiseErr: 1'b0};
    if (hdlEntry) begin
      if (!hit) begin
        strb.actSel = ACT_SAV;
      end else if (tgtCtx != curAct) begin
        if (ctxValid[curAct]) begin
          strb.raiseErr = 1'b1;
        end else begin
          strb.actSel     = ACT_TGT;
          strb.savFromAct = 1'b1;
        end
      end
    end else if (regWrEn) begin
      if (wrCtx == '0 || permMask[wrAct]) strb.actSel = ACT_WR;
      strb.savFromWr = (wrCtx == '0);
    end
  end
endmodule

// File: rtl/ctx_dp.sv
module ctx_dp
  import ctx_pkg::*;
#(
  parameter int CTX_W   = 4,
  parameter int REG_W   = 32,
  parameter int SAV_LSB = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctxStrb_t         strb,
  input  logic [CTX_W-1:0] tgtCtx,
  input  logic [REG_W-1:0] regWrData,
  output logic [CTX_W-1:0] curAct,
  output logic [REG_W-1:0] rdData,
  output logic             busErr
);
  logic [CTX_W-1:0] actQ, savQ;
  logic             errQ;
  logic [CTX_W-1:0] wrAct, wrSav;

  assign wrAct = regWrData[CTX_W-1:0];
  assign wrSav = regWrData[SAV_LSB +: CTX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actQ <= '0;
      savQ <= '0;
      errQ <= 1'b0;
    end else begin
      errQ <= strb.raiseErr;
      unique case (strb.actSel)
        ACT_TGT:  actQ <= tgtCtx;
        ACT_SAV:  actQ <= savQ;
        ACT_WR:   actQ <= wrAct;
        default:  actQ <= actQ;
      endcase
      if (strb.savFromAct)     savQ <= actQ;
      else if (strb.savFromWr) savQ <= wrSav;
    end
  end

  always_comb begin
    rdData                    = '0;
    rdData[CTX_W-1:0]         = actQ;
    rdData[SAV_LSB +: CTX_W]  = savQ;
  end

  assign curAct = actQ;
  assign busErr = errQ;
endmodule

// File: rtl/ctx_switch_reg.sv
module ctx_switch_reg
  import ctx_pkg::*;
#(
  parameter int CTX_W   = 4,
  parameter int NUM_HDL = 4,
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 32,
  parameter int SAV_LSB = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWrEn,
  input  logic [REG_W-1:0]               regWrData,
  input  logic [CTX_W-1:0]               wrCtx,
  input  logic [(1<<CTX_W)-1:0]          permMask,
  output logic [REG_W-1:0]               rdData,
  input  logic                           hdlEntry,
  input  logic [ADDR_W-1:0]              hdlAddr,
  input  logic [NUM_HDL-1:0][ADDR_W-1:0] hdlAddrTab,
  input  logic [(1<<CTX_W)-1:0]          ctxValid,
  output logic                           busErr
);
  ctxStrb_t         strb;
  logic [CTX_W-1:0] tgtCtx, curAct;

  ctx_ctrl #(.CTX_W(CTX_W), .NUM_HDL(NUM_HDL), .ADDR_W(ADDR_W)) uCtrl (
    .hdlEntry(hdlEntry), .hdlAddr(hdlAddr), .hdlAddrTab(hdlAddrTab),
    .ctxValid(ctxValid), .regWrEn(regWrEn), .wrCtx(wrCtx),
    .wrAct(regWrData[CTX_W-1:0]), .permMask(permMask), .curAct(curAct),
    .strb(strb), .tgtCtx(tgtCtx)
  );

  ctx_dp #(.CTX_W(CTX_W), .REG_W(REG_W), .SAV_LSB(SAV_LSB)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .tgtCtx(tgtCtx),
    .regWrData(regWrData), .curAct(curAct), .rdData(rdData), .busErr(busErr)
  );
endmodule

// File: rtl/ctx_switch_chk.sv
module ctx_switch_chk #(
  parameter int CTX_W   = 4,
  parameter int NUM_HDL = 4,
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 32,
  parameter int SAV_LSB = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           regWrEn,
  input logic [CTX_W-1:0]               wrCtx,
  input logic [REG_W-1:0]               rdData,
  input logic                           hdlEntry,
  input logic [ADDR_W-1:0]              hdlAddr,
  input logic [NUM_HDL-1:0][ADDR_W-1:0] hdlAddrTab,
  input logic                           busErr
);
  localparam logic [REG_W-1:0] FIELD_MASK =
    (REG_W'((1 << CTX_W) - 1)) | (REG_W'((1 << CTX_W) - 1) << SAV_LSB);

  logic anyHit;
  always_comb begin
    anyHit = 1'b0;
    for (int k = 0; k < NUM_HDL; k++)
      if (hdlAddrTab[k] == hdlAddr) anyHit = 1'b1;
  end

  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdData & ~FIELD_MASK) == '0);

  p_sav_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !hdlEntry && wrCtx != '0) |=>
      rdData[SAV_LSB +: CTX_W] == $past(rdData[SAV_LSB +: CTX_W]));

  p_err_after_entry_r6: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(hdlEntry));

  p_err_no_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $stable(rdData));

  p_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (hdlEntry && !anyHit) |=>
      (rdData[CTX_W-1:0] == $past(rdData[SAV_LSB +: CTX_W])) && !busErr);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!hdlEntry && !regWrEn) |=> $stable(rdData) && !busErr);
endmodule

bind ctx_switch_reg ctx_switch_chk #(
  .CTX_W(CTX_W), .NUM_HDL(NUM_HDL), .ADDR_W(ADDR_W), .REG_W(REG_W), .SAV_LSB(SAV_LSB)
) uChk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .wrCtx(wrCtx), .rdData(rdData),
  .hdlEntry(hdlEntry), .hdlAddr(hdlAddr), .hdlAddrTab(hdlAddrTab), .busErr(busErr)
);

// File: tb/sim_ctx_switch_reg.sv
module sim_ctx_switch_reg;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [31:0]       regWrData = '0;
  logic [3:0]        wrCtx = '0;
  logic [15:0]       permMask = '0;
  logic [31:0]       rdData;
  logic              hdlEntry = 1'b0;
  logic [31:0]       hdlAddr = '0;
  logic [3:0][31:0]  hdlAddrTab;
  logic [15:0]       ctxValid = '0;
  logic              busErr;

  int compared = 0;
  int mismatched = 0;
  int expAct = 0;
  int expSav = 0;
  bit expErr = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ctx_switch_reg u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .wrCtx(wrCtx), .permMask(permMask), .rdData(rdData), .hdlEntry(hdlEntry),
    .hdlAddr(hdlAddr), .hdlAddrTab(hdlAddrTab), .ctxValid(ctxValid), .busErr(busErr)
  );

  task automatic compare(input string tag);
    logic [31:0] expRd;
    expRd = {12'd0, 4'(expSav), 12'd0, 4'(expAct)};
    compared++;
    if (rdData !== expRd || busErr !== expErr) begin
      mismatched++;
      $display("FAIL %s: rdData=%h busErr=%b expected rdData=%h busErr=%b",
               tag, rdData, busErr, expRd, expErr);
    end
  endtask

  // Reference: apply one cycle of behaviour to the model
  task automatic model();
    int tgt;
    tgt = -1;
    expErr = 0;
    if (hdlEntry) begin
      for (int k = 0; k < 4; k++)
        if (tgt < 0 && hdlAddrTab[k] == hdlAddr) tgt = k;
      if (tgt < 0) expAct = expSav;
      else if (tgt != expAct) begin
        if (ctxValid[expAct]) expErr = 1;
        else begin expSav = expAct; expAct = tgt; end
      end
    end else if (regWrEn) begin
      if (wrCtx == 0) begin
        expAct = int'(regWrData[3:0]);
        expSav = int'(regWrData[19:16]);
      end else if (permMask[regWrData[3:0]]) begin
        expAct = int'(regWrData[3:0]);
      end
    end
  endtask

  // Drive at falling edge, update model at rising edge, compare at next falling edge
  task automatic step(input bit ent, input logic [31:0] addr, input bit wr,
                      input logic [3:0] wc, input logic [31:0] data, input string tag);
    hdlEntry = ent; hdlAddr = addr; regWrEn = wr; wrCtx = wc; regWrData = data;
    @(posedge clk);
    model();
    @(negedge clk);
    hdlEntry = 1'b0; regWrEn = 1'b0;
    compare(tag);
  endtask

  initial begin
    hdlAddrTab[0] = 32'h100; hdlAddrTab[1] = 32'h140;
    hdlAddrTab[2] = 32'h180; hdlAddrTab[3] = 32'h1C0;
    repeat (3) @(negedge clk);
    compare("R1 reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after release");
    step(0, 0, 1, 4'd0, 32'hFFFF_FFFF, "R1 R2 reserved bits");
    step(0, 0, 1, 4'd0, 32'h0005_0003, "R2 ctx0 write masks zero");
    step(0, 0, 1, 4'd2, 32'h0009_0007, "R3 R4 denied write");
    permMask = 16'h0080;
    step(0, 0, 1, 4'd2, 32'h0009_0007, "R3 R4 permitted write");
    step(0, 32'h140, 0, 4'd0, 0, "R7 push");
    step(1, 32'h140, 0, 4'd0, 0, "R7 push");
    step(1, 32'h140, 0, 4'd0, 0, "R5 same target");
    ctxValid = 16'h0002;
    step(1, 32'h180, 0, 4'd0, 0, "R6 refused switch");
    step(0, 0, 0, 4'd0, 0, "R6 pulse ends");
    step(1, 32'h999, 0, 4'd0, 0, "R8 pop");
    ctxValid = 16'h0000;
    step(1, 32'h100, 1, 4'd0, 32'h000A_000B, "R9 hw beats sw");
    step(1, 32'h7777, 0, 4'd0, 0, "R8 pop again");
    step(0, 0, 1, 4'd0, 32'h0000_0005, "R2 set context 5");
    hdlAddrTab[2] = 32'h200; hdlAddrTab[3] = 32'h200;
    step(1, 32'h200, 0, 4'd0, 0, "R10 lowest slot");
    step(1, 32'h1C0, 1, 4'd0, 32'h000F_000F, "R8 R9 pop with write");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule